// File: doc/BRIEF.md
# Delay Tap Sweep Calibrator

This block tunes the read-capture delay of a memory interface without software help. Once started, it walks a tap setting from the lowest value to the highest. For each setting it drives that value onto every byte-lane delay output. It then runs one trial on an external memory self-test engine through a start/done/status handshake and decides whether the setting worked.

While it sweeps, it counts the passing settings and keeps the first and the latest passing tap. When the sweep is complete it programs the centre of that span on all lanes. If no setting passed, it programs a fixed fallback tap instead. Completion is marked by a single-cycle done pulse, and the chosen tap stays on the lane outputs until the next calibration.

The window centre uses the first and last passing taps over the whole sweep, even when failing taps lie between them. A trial that never reports completion is cut off by a timeout and treated as a failure.

Top module: `tap_sweep_cal`

## Requirements
- R1: After reset `busy`, `cal_done` and `bist_start` are 0, every lane output and `last_pass` are 0, `pass_count` is 0 and `first_pass` reads 32'hAA55AA55.
- R2: A `cal_start` pulse while idle raises `busy` on the next cycle. The block then runs exactly one self-test trial per tap, in increasing order from 0 to 2^TAP_W-1. `bist_start` is never high while `busy` is low.
- R3: While `bist_start` is high, all lane outputs carry the same value, which is the tap under trial.
- R4: `bist_start` stays high until `bist_status[0]` (trial complete) has been seen high, or until the trial times out. It drops on the clock edge after that.
- R5: A trial passes only when the failure field `bist_status[16:9]` is zero and the pass field `bist_status[8:1]` equals the run count field `run_cfg[8:1]`. An off-by-one pass field or any nonzero failure field is a failing trial.
- R6: `first_pass` reads 32'hAA55AA55 until a tap passes. The first passing tap is then stored in both `first_pass` and `last_pass`, and each later passing tap updates `last_pass` only. `last_pass` is 0 before any pass.
- R7: `pass_count` is cleared at start and increases by exactly one for each passing tap.
- R8: With at least one pass, the final tap is (first + last) >> 1, truncated to TAP_W bits. This holds even when failing taps lie between first and last.
- R9: With no passing tap, the final tap is DEFAULT_TAP (8).
- R10: `cal_done` is a one-cycle pulse with `busy` low. At that pulse, every lane output carries the final tap, and the value stays stable until the next start.
- R11: A `cal_start` pulse during a sweep is ignored. The sweep neither restarts nor adds trials.
- R12: With the timeout enabled, a trial whose `bist_status[0]` never rises keeps `bist_start` high for exactly TIMEOUT_CYC cycles and counts as failing.
- R13: The run count is sampled at start, so changes to `run_cfg` during a sweep have no effect on the pass decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Single-cycle calibration start request |
| run_cfg | input | CFG_W | Run configuration word; bits [CNT_W:1] give the expected pass count |
| busy | output | 1 | High while a sweep is in progress |
| cal_done | output | 1 | One-cycle completion pulse |
| lane_tap | output | LANES*TAP_W | Delay tap for every byte lane, lane 0 in the low bits |
| bist_start | output | 1 | Self-test run request |
| bist_status | input | STAT_W | Bit 0 done, [CNT_W:1] pass runs, [2*CNT_W:CNT_W+1] failing runs |
| pass_count | output | TAP_W+1 | Number of passing taps in the current or last sweep |
| first_pass | output | 32 | First passing tap, or the sentinel 32'hAA55AA55 |
| last_pass | output | TAP_W | Most recent passing tap |

## Verification
The bench keeps the default 6-bit tap, four lanes and 8-bit count fields, so each calibration runs the full 64-trial sweep and the window arithmetic meets its real edge values (taps 0 and 63). TIMEOUT_CYC is reduced to 40 so that trials that never complete are cheap. Several hung taps can then appear in one sweep, and the exact abort length can be measured within the cycle budget.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SET,
      ST_RUN,
      ST_NEXT,
      ST_FIN
   } tsc_state_e;

   localparam logic [31:0] TSC_NO_PASS = 32'hAA55AA55;
endpackage

// File: rtl/tsc_judge.sv
module tsc_judge #(
   parameter int CNT_W  = 8,
   parameter int STAT_W = 32
) (
   input  logic [STAT_W-1:0] status,
   input  logic [CNT_W-1:0]  runs,
   output logic              pass
);
   localparam int PASS_LO = 1;
   localparam int FAIL_LO = CNT_W + 1;

   if (STAT_W < 2 * CNT_W + 1) begin : g_bad_stat
      $error("tsc_judge: STAT_W too narrow for both count fields");
   end

   logic [CNT_W-1:0] good_runs;
   logic [CNT_W-1:0] bad_runs;
   logic             unused_status;

   assign good_runs     = status[PASS_LO +: CNT_W];
   assign bad_runs      = status[FAIL_LO +: CNT_W];
   assign unused_status = ^status;
   assign pass          = (bad_runs == '0) && (good_runs == runs);
endmodule

// File: rtl/tsc_window.sv
module tsc_window
   import tsc_pkg::*;
#(
   parameter int TAP_W       = 6,
   parameter int DEFAULT_TAP = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             rec,
   input  logic [TAP_W-1:0] tap,
   output logic [TAP_W:0]   cnt,
   output logic [31:0]      first,
   output logic [TAP_W-1:0] last,
   output logic [TAP_W-1:0] final_tap
);
   localparam logic [TAP_W-1:0] DEF_TAP = TAP_W'(DEFAULT_TAP);
   localparam logic [TAP_W:0]   CNT_ONE = (TAP_W+1)'(1);

   if (DEFAULT_TAP < 0 || DEFAULT_TAP >= (1 << TAP_W)) begin : g_bad_def
      $error("tsc_window: DEFAULT_TAP outside the tap range");
   end

   logic [TAP_W:0] sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         first <= TSC_NO_PASS;
         last  <= '0;
      end else if (clr) begin
         cnt   <= '0;
         first <= TSC_NO_PASS;
         last  <= '0;
      end else if (rec) begin
         cnt  <= cnt + CNT_ONE;
         last <= tap;
         if (first == TSC_NO_PASS) begin
            first <= 32'(tap);
         end
      end
   end

   assign sum       = {1'b0, first[TAP_W-1:0]} + {1'b0, last};
   assign final_tap = (cnt != '0) ? sum[TAP_W:1] : DEF_TAP;
endmodule

// File: rtl/tsc_timeout.sv
module tsc_timeout #(
   parameter bit TIMEOUT_EN  = 1'b1,
   parameter int TIMEOUT_CYC = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic hit
);
   if (TIMEOUT_EN) begin : g_timer
      localparam int CW = $clog2(TIMEOUT_CYC) + 1;
      localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);
      localparam logic [CW-1:0] ONE  = CW'(1);

      if (TIMEOUT_CYC < 2) begin : g_bad_cyc
         $error("tsc_timeout: TIMEOUT_CYC must be at least 2");
      end

      logic [CW-1:0] ticks;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ticks <= '0;
         end else if (!run) begin
            ticks <= '0;
         end else begin
            ticks <= ticks + ONE;
         end
      end

      assign hit = run && (ticks == LAST);
   end else begin : g_no_timer
      logic unused_tmo;
      assign unused_tmo = clk ^ rst_n ^ run;
      assign hit        = 1'b0;
   end
endmodule

// File: rtl/tap_sweep_cal.sv
module tap_sweep_cal
   import tsc_pkg::*;
#(
   parameter int TAP_W       = 6,
   parameter int LANES       = 4,
   parameter int CNT_W       = 8,
   parameter int CFG_W       = 32,
   parameter int STAT_W      = 32,
   parameter int DEFAULT_TAP = 8,
   parameter bit TIMEOUT_EN  = 1'b1,
   parameter int TIMEOUT_CYC = 4096
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cal_start,
   input  logic [CFG_W-1:0]       run_cfg,
   output logic                   busy,
   output logic                   cal_done,
   output logic [LANES*TAP_W-1:0] lane_tap,
   output logic                   bist_start,
   input  logic [STAT_W-1:0]      bist_status,
   output logic [TAP_W:0]         pass_count,
   output logic [31:0]            first_pass,
   output logic [TAP_W-1:0]       last_pass
);
   localparam logic [TAP_W-1:0] TAP_LAST = '1;
   localparam logic [TAP_W-1:0] TAP_ONE  = TAP_W'(1);

   if (TAP_W < 1 || TAP_W > 16) begin : g_bad_tap
      $error("tap_sweep_cal: TAP_W must lie in 1..16");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("tap_sweep_cal: LANES must be positive");
   end
   if (CFG_W < CNT_W + 1) begin : g_bad_cfg
      $error("tap_sweep_cal: CFG_W too narrow for the run count field");
   end

   tsc_state_e       state_q;
   logic [TAP_W-1:0] tap_q;
   logic [TAP_W-1:0] drive_q;
   logic [CNT_W-1:0] runs_q;
   logic             bstart_q;
   logic             done_q;
   logic             trial_pass;
   logic             tmo_hit;
   logic             rec_pass;
   logic             clr_win;
   logic [TAP_W-1:0] final_tap;
   logic             unused_cfg;

   assign unused_cfg = ^run_cfg;
   assign clr_win    = (state_q == ST_IDLE) && cal_start;
   assign rec_pass   = (state_q == ST_RUN) && bist_status[0] && trial_pass;

   tsc_judge #(
      .CNT_W (CNT_W),
      .STAT_W(STAT_W)
   ) u_judge (
      .status(bist_status),
      .runs  (runs_q),
      .pass  (trial_pass)
   );

   tsc_timeout #(
      .TIMEOUT_EN (TIMEOUT_EN),
      .TIMEOUT_CYC(TIMEOUT_CYC)
   ) u_tmo (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state_q == ST_RUN),
      .hit  (tmo_hit)
   );

   tsc_window #(
      .TAP_W      (TAP_W),
      .DEFAULT_TAP(DEFAULT_TAP)
   ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_win),
      .rec      (rec_pass),
      .tap      (tap_q),
      .cnt      (pass_count),
      .first    (first_pass),
      .last     (last_pass),
      .final_tap(final_tap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         tap_q    <= '0;
         drive_q  <= '0;
         runs_q   <= '0;
         bstart_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (cal_start) begin
                  runs_q  <= run_cfg[CNT_W:1];
                  tap_q   <= '0;
                  drive_q <= '0;
                  state_q <= ST_SET;
               end
            end
            ST_SET: begin
               bstart_q <= 1'b1;
               state_q  <= ST_RUN;
            end
            ST_RUN: begin
               if (bist_status[0] || tmo_hit) begin
                  bstart_q <= 1'b0;
                  state_q  <= ST_NEXT;
               end
            end
            ST_NEXT: begin
               if (tap_q == TAP_LAST) begin
                  state_q <= ST_FIN;
               end else begin
                  tap_q   <= tap_q + TAP_ONE;
                  drive_q <= tap_q + TAP_ONE;
                  state_q <= ST_SET;
               end
            end
            ST_FIN: begin
               drive_q <= final_tap;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_tap[g*TAP_W +: TAP_W] = drive_q;
   end

   assign busy       = (state_q != ST_IDLE);
   assign cal_done   = done_q;
   assign bist_start = bstart_q;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
   parameter int TAP_W  = 6,
   parameter int LANES  = 4,
   parameter int STAT_W = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cal_start,
   input logic                   busy,
   input logic                   cal_done,
   input logic [LANES*TAP_W-1:0] lane_tap,
   input logic                   bist_start,
   input logic [STAT_W-1:0]      bist_status,
   input logic [TAP_W:0]         pass_count,
   input logic [31:0]            first_pass,
   input logic                   tmo_hit
);
   localparam logic [TAP_W:0] ONE = (TAP_W+1)'(1);

   logic unused_chk;
   assign unused_chk = ^bist_status;

   for (genvar g = 1; g < LANES; g++) begin : g_lane_chk
      assert_lanes_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
         bist_start |-> (lane_tap[g*TAP_W +: TAP_W] == lane_tap[TAP_W-1:0]));
   end

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bist_start);

   assert_start_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bist_start) |-> ($past(bist_status[0]) || $past(tmo_hit)));

   assert_sentinel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_count == '0) |-> (first_pass == 32'hAA55AA55));

   assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_count != $past(pass_count)) |->
         ((pass_count == $past(pass_count) + ONE) || (pass_count == '0)));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> !cal_done);

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |-> !busy);

   assert_final_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy) && !$past(cal_start)) |-> $stable(lane_tap));
endmodule

bind tap_sweep_cal tsc_checker #(
   .TAP_W (TAP_W),
   .LANES (LANES),
   .STAT_W(STAT_W)
) u_tsc_checker (.*);

// File: tb/test_tap_sweep_cal.sv
module test_tap_sweep_cal;
   localparam int TAP_W = 6;
   localparam int LANES = 4;
   localparam int NTAP  = 64;
   localparam int TMO   = 40;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   cal_start = 1'b0;
   logic [31:0]            run_cfg = '0;
   logic                   busy;
   logic                   cal_done;
   logic [LANES*TAP_W-1:0] lane_tap;
   logic                   bist_start;
   logic [31:0]            bist_status;
   logic [TAP_W:0]         pass_count;
   logic [31:0]            first_pass;
   logic [TAP_W-1:0]       last_pass;

   always #5 clk = ~clk;

   tap_sweep_cal #(
      .TAP_W      (TAP_W),
      .LANES      (LANES),
      .TIMEOUT_CYC(TMO)
   ) i_tap_sweep_cal (
      .clk        (clk),
      .rst_n      (rst_n),
      .cal_start  (cal_start),
      .run_cfg    (run_cfg),
      .busy       (busy),
      .cal_done   (cal_done),
      .lane_tap   (lane_tap),
      .bist_start (bist_start),
      .bist_status(bist_status),
      .pass_count (pass_count),
      .first_pass (first_pass),
      .last_pass  (last_pass)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;
   int cyc = 0;

   // per-tap responder behaviour: 0 pass, 1 failures, 2 pass count off by one, 3 hang
   int mode[NTAP];
   int lat[NTAP];
   int resp_runs = 0;
   int rcnt = 0;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   function automatic logic [31:0] mk_status(int t);
      int p;
      int f;
      p = resp_runs;
      f = 0;
      if (mode[t] == 1) f = 1 + (t % 5);
      if (mode[t] == 2) p = (resp_runs + 1) & 255;
      return {15'b0, f[7:0], p[7:0], 1'b1};
   endfunction

   // external self-test engine model
   always @(posedge clk) begin
      if (!rst_n || !bist_start) begin
         bist_status <= '0;
         rcnt        <= 0;
      end else if (!bist_status[0] && mode[lane_tap[TAP_W-1:0]] != 3) begin
         if (rcnt >= lat[lane_tap[TAP_W-1:0]]) bist_status <= mk_status(int'(lane_tap[TAP_W-1:0]));
         else rcnt <= rcnt + 1;
      end
   end

   // trial monitor
   bit mon_en = 0;
   bit prev_bs = 0;
   int exp_tap = 0;
   int trials = 0;
   int hlen = 0;
   int cur_tap = 0;

   always @(negedge clk) begin
      if (mon_en) begin
         if (bist_start && !prev_bs) begin
            chk(int'(lane_tap[TAP_W-1:0]) == exp_tap, "R2", "trial tap order",
                lane_tap[TAP_W-1:0], exp_tap);
            for (int l = 1; l < LANES; l++)
               chk(lane_tap[l*TAP_W +: TAP_W] == lane_tap[TAP_W-1:0], "R3", "lane equal",
                   lane_tap[l*TAP_W +: TAP_W], lane_tap[TAP_W-1:0]);
            cur_tap = int'(lane_tap[TAP_W-1:0]);
            exp_tap++;
            trials++;
         end
         if (bist_start) hlen++;
         if (!bist_start && prev_bs) begin
            if (mode[cur_tap] == 3) chk(hlen == TMO, "R12", "hung trial length", hlen, TMO);
            hlen = 0;
         end
      end
      prev_bs = bist_start;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         n_bad++;
         $display("FAIL R2 watchdog: actual %0d cycles expected below 150000", cyc);
         finish_run();
      end
   end

   task automatic run_sweep(string tag, int runs, bit disturb);
      int e_cnt;
      int e_first;
      int e_last;
      int e_final;
      e_cnt = 0;
      e_first = 32'hAA55AA55;
      e_last = 0;
      for (int t = 0; t < NTAP; t++) begin
         if (mode[t] == 0) begin
            if (e_cnt == 0) e_first = t;
            e_last = t;
            e_cnt++;
         end
      end
      e_final = (e_cnt != 0) ? (((e_first + e_last) >> 1) & 63) : 8;

      resp_runs = runs;
      run_cfg   = ($urandom & 32'hFFFF_FE01) | (32'(runs) << 1);
      exp_tap   = 0;
      trials    = 0;
      hlen      = 0;
      mon_en    = 1;
      @(negedge clk) cal_start = 1'b1;
      @(negedge clk) cal_start = 1'b0;
      chk(busy == 1'b1, "R2", {tag, " busy after start"}, busy, 1);
      if (disturb) begin
         repeat (60) @(negedge clk);
         chk(busy == 1'b1, "R11", {tag, " busy mid sweep"}, busy, 1);
         cal_start = 1'b1;
         run_cfg   = run_cfg ^ 32'h0000_01FE; // R13: new run count mid sweep
         @(negedge clk) cal_start = 1'b0;
      end
      while (!cal_done && !finished) @(negedge clk);
      chk(trials == NTAP, "R11", {tag, " trial count"}, trials, NTAP);
      for (int l = 0; l < LANES; l++)
         chk(int'(lane_tap[l*TAP_W +: TAP_W]) == e_final, (e_cnt != 0) ? "R8" : "R9",
             {tag, " final lane tap"}, lane_tap[l*TAP_W +: TAP_W], e_final);
      chk(int'(pass_count) == e_cnt, "R7", {tag, " pass count"}, pass_count, e_cnt);
      chk(first_pass == 32'(e_first), "R6", {tag, " first pass"}, first_pass, e_first);
      chk(int'(last_pass) == e_last, "R6", {tag, " last pass"}, last_pass, e_last);
      chk(busy == 1'b0, "R10", {tag, " busy at done"}, busy, 0);
      mon_en = 0;
      @(negedge clk);
      chk(cal_done == 1'b0, "R10", {tag, " done width"}, cal_done, 0);
      repeat (3) @(negedge clk);
      chk(int'(lane_tap[TAP_W-1:0]) == e_final, "R10", {tag, " final held"},
          lane_tap[TAP_W-1:0], e_final);
   endtask

   task automatic set_all(int m);
      for (int t = 0; t < NTAP; t++) begin
         mode[t] = m;
         lat[t]  = int'($urandom % 4);
      end
   endtask

   task automatic set_random(int hang_pct);
      for (int t = 0; t < NTAP; t++) begin
         int r;
         r = int'($urandom % 100);
         if (r < hang_pct) mode[t] = 3;
         else if (r < 55) mode[t] = 0;
         else mode[t] = 1 + int'($urandom % 2);
         lat[t] = int'($urandom % 6);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      set_all(0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(busy == 1'b0, "R1", "busy", busy, 0);
      chk(cal_done == 1'b0, "R1", "done", cal_done, 0);
      chk(bist_start == 1'b0, "R1", "bist_start", bist_start, 0);
      chk(lane_tap == '0, "R1", "lanes", lane_tap, 0);
      chk(pass_count == '0, "R1", "pass count", pass_count, 0);
      chk(first_pass == 32'hAA55AA55, "R1", "first", first_pass, 32'hAA55AA55);
      chk(last_pass == '0, "R1", "last", last_pass, 0);

      set_all(0);
      run_sweep("all pass", 8, 0);

      set_all(1);
      run_sweep("none pass", 8, 0);   // R9 default tap

      set_all(2);
      run_sweep("count off by one", 17, 0);   // R5

      set_all(1);
      mode[63] = 0;
      run_sweep("only top", 200, 0);

      set_all(2);
      mode[0] = 0;
      mode[63] = 0;
      run_sweep("both ends", 3, 0);

      set_all(1);
      for (int t = 5; t <= 10; t++) mode[t] = 0;
      for (int t = 40; t <= 50; t++) mode[t] = 0;
      run_sweep("split window", 99, 0);   // R8 noncontiguous

      set_random(0);
      run_sweep("random a", int'($urandom % 256), 0);

      set_random(12);
      run_sweep("random hang", int'($urandom % 256), 0);   // R12

      set_random(5);
      run_sweep("disturbed", 1 + int'($urandom % 254), 1);   // R11 R13

      finish_run();
   end
endmodule